// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block runs when the translation cache misses. It takes one virtual address together with the table base and the table length of the current address space. It then reads a forward-mapped two-level page table from memory and returns one of two results: a physical frame number with its access rights, or a fault code. The virtual address has three fields. The top 10 bits index the outer table, the next 10 bits index an inner table, and the low 12 bits are the byte offset in a 4 KB page. Each table entry is one 32-bit word, so each inner table is 1024 entries long and fills exactly one page.

The walk reads two words, one after the other, on a request/response memory port. The first read uses the outer index and the base. The entry it returns gives the frame that holds the inner table. The second read uses the inner index within that frame. A bound check against the length input comes first, and each entry read is then checked for validity. Any of these checks can end the walk early. The caller sees a single-cycle response pulse. After that pulse the walker is idle and can accept the next request.

Top module: `pt_walker`

## Requirements
- R1: While `rst` is high, `req_ready` is 1, and `mem_req_valid` and `rsp_valid` are 0.
- R2: The walker accepts a request only when `req_ready` is high. It lowers `req_ready` from the cycle after it accepts a request until the response has been given. Requests raised while the walker is busy have no effect.
- R3: The first memory read goes to `req_base + 4*vaddr[31:22]`.
- R4: If the outer entry has bit 0 set, the second read goes to `{outer_entry[31:12], vaddr[21:12], 2'b00}`.
- R5: If the inner entry has bit 0 set, the response has `rsp_fault`=0 and `rsp_kind`=0. It carries `rsp_frame`=inner_entry[31:12] and `rsp_perm`=inner_entry[3:1], where perm bit 0 is read, bit 1 is write and bit 2 is execute. It also carries `rsp_paddr`={frame, vaddr[11:0]}. A successful walk makes exactly two memory reads.
- R6: If vaddr[31:22] >= `req_len`, the walk faults with `rsp_kind`=1 and makes no memory read. A `req_len` of 0 therefore faults every address, and a `req_len` of 1024 allows every outer index.
- R7: If the outer entry has bit 0 clear, the walk faults with `rsp_kind`=2 after exactly one read.
- R8: If the inner entry has bit 0 clear, the walk faults with `rsp_kind`=3 after two reads. `rsp_fault` is 1 exactly when `rsp_kind` is not 0.
- R9: Once `mem_req_valid` is raised, it stays high with `mem_req_addr` unchanged until `mem_req_ready` is sampled high. Responses may arrive any number of cycles later.
- R10: `rsp_valid` is high for exactly one cycle, and `req_ready` is high in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Walk request strobe |
| req_ready | output | 1 | Walker idle, request accepted when both high |
| req_vaddr | input | 32 | Virtual address to translate |
| req_base | input | 32 | Byte address of the outer table |
| req_len | input | 11 | Number of valid outer-table entries |
| mem_req_valid | output | 1 | Memory word read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_kind | output | 2 | 0 ok, 1 bound, 2 outer invalid, 3 inner invalid |
| rsp_frame | output | 20 | Physical frame number |
| rsp_perm | output | 3 | Access rights {execute, write, read} |
| rsp_paddr | output | 32 | Physical byte address |

## Verification
The hardest case to reach from the ports is a request that arrives while a walk is still in flight. It should be ignored, but a wrong design could latch it silently. The bench holds `req_valid` high with a different address for several cycles during a walk. It then checks that `req_ready` stays low, and that exactly one response comes back and that it matches the first address. The memory model stalls `ready` on a rotating pattern and varies its response latency, so the request-hold rule is exercised at both levels. The table contents cover outer indices at zero, at the length limit minus one, at the limit itself and at the top index with a full-size length.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_OUTER,
    ST_WT_OUTER,
    ST_RD_INNER,
    ST_WT_INNER,
    ST_DONE,
    ST_FAULT
  } walk_state_t;

  typedef enum logic [1:0] {
    FK_NONE  = 2'd0,
    FK_BOUND = 2'd1,
    FK_OUTER = 2'd2,
    FK_INNER = 2'd3
  } fault_kind_t;

  // log2 of the entry size in bytes
  localparam int ENT_LG = 2;
endpackage

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int PERM_W = 3
) (
  input  logic [ADDR_W-1:0]       entry,
  output logic                    ent_valid,
  output logic [ADDR_W-OFF_W-1:0] ent_frame,
  output logic [PERM_W-1:0]       ent_perm
);
  logic unused_mid;

  assign ent_valid  = entry[0];
  assign ent_perm   = entry[PERM_W:1];
  assign ent_frame  = entry[ADDR_W-1:OFF_W];
  assign unused_mid = ^entry[OFF_W-1:PERM_W+1];
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int ENT_LG = 2
) (
  input  logic [ADDR_W-1:0]              base,
  input  logic [IDX_W-1:0]               outer_idx,
  input  logic [ADDR_W-IDX_W-ENT_LG-1:0] table_frame,
  input  logic [IDX_W-1:0]               inner_idx,
  output logic [ADDR_W-1:0]              outer_addr,
  output logic [ADDR_W-1:0]              inner_addr
);
  localparam int PAD_W = ADDR_W - IDX_W - ENT_LG;

  assign outer_addr = base + {{PAD_W{1'b0}}, outer_idx, {ENT_LG{1'b0}}};
  assign inner_addr = {table_frame, inner_idx, {ENT_LG{1'b0}}};
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int PERM_W = 3
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              req_valid,
  output logic                              req_ready,
  input  logic [ADDR_W-1:0]                 req_vaddr,
  input  logic [ADDR_W-1:0]                 req_base,
  input  logic [IDX_W:0]                    req_len,
  output logic                              mem_req_valid,
  input  logic                              mem_req_ready,
  output logic [ADDR_W-1:0]                 mem_req_addr,
  input  logic                              mem_rsp_valid,
  input  logic [ADDR_W-1:0]                 mem_rsp_data,
  output logic                              rsp_valid,
  output logic                              rsp_fault,
  output logic [1:0]                        rsp_kind,
  output logic [ADDR_W-IDX_W-ptw_pkg::ENT_LG-1:0] rsp_frame,
  output logic [PERM_W-1:0]                 rsp_perm,
  output logic [ADDR_W-1:0]                 rsp_paddr
);
  import ptw_pkg::*;

  // page offset width equals inner index plus entry size, so one inner table fills one page
  localparam int OFF_W   = IDX_W + ENT_LG;
  localparam int FRAME_W = ADDR_W - OFF_W;
  localparam int LOW_W   = OFF_W + IDX_W;

  walk_state_t             state_q;
  fault_kind_t             kind_q;
  logic [LOW_W-1:0]        vlow_q;
  logic [FRAME_W-1:0]      frame_q;
  logic [PERM_W-1:0]       perm_q;
  logic [ADDR_W-1:0]       addr_q;

  logic [IDX_W-1:0]        p1_in;
  logic [ADDR_W-1:0]       outer_addr;
  logic [ADDR_W-1:0]       inner_addr;
  logic                    dec_valid;
  logic [FRAME_W-1:0]      dec_frame;
  logic [PERM_W-1:0]       dec_perm;

  assign p1_in = req_vaddr[ADDR_W-1 -: IDX_W];

  ptw_addr_gen #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .ENT_LG(ENT_LG)
  ) u_addr (
    .base       (req_base),
    .outer_idx  (p1_in),
    .table_frame(dec_frame),
    .inner_idx  (vlow_q[OFF_W +: IDX_W]),
    .outer_addr (outer_addr),
    .inner_addr (inner_addr)
  );

  ptw_entry_decode #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .PERM_W(PERM_W)
  ) u_dec (
    .entry    (mem_rsp_data),
    .ent_valid(dec_valid),
    .ent_frame(dec_frame),
    .ent_perm (dec_perm)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      kind_q  <= FK_NONE;
      vlow_q  <= '0;
      frame_q <= '0;
      perm_q  <= '0;
      addr_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            vlow_q <= req_vaddr[LOW_W-1:0];
            addr_q <= outer_addr;
            kind_q <= FK_NONE;
            if ({1'b0, p1_in} >= req_len) begin
              kind_q  <= FK_BOUND;
              state_q <= ST_FAULT;
            end else begin
              state_q <= ST_RD_OUTER;
            end
          end
        end
        ST_RD_OUTER: if (mem_req_ready) state_q <= ST_WT_OUTER;
        ST_WT_OUTER: begin
          if (mem_rsp_valid) begin
            if (!dec_valid) begin
              kind_q  <= FK_OUTER;
              state_q <= ST_FAULT;
            end else begin
              addr_q  <= inner_addr;
              state_q <= ST_RD_INNER;
            end
          end
        end
        ST_RD_INNER: if (mem_req_ready) state_q <= ST_WT_INNER;
        ST_WT_INNER: begin
          if (mem_rsp_valid) begin
            if (!dec_valid) begin
              kind_q  <= FK_INNER;
              state_q <= ST_FAULT;
            end else begin
              frame_q <= dec_frame;
              perm_q  <= dec_perm;
              state_q <= ST_DONE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_RD_OUTER) || (state_q == ST_RD_INNER);
  assign mem_req_addr  = addr_q;
  assign rsp_valid     = (state_q == ST_DONE) || (state_q == ST_FAULT);
  assign rsp_fault     = (state_q == ST_FAULT);
  assign rsp_kind      = kind_q;
  assign rsp_frame     = frame_q;
  assign rsp_perm      = perm_q;
  assign rsp_paddr     = {frame_q, vlow_q[OFF_W-1:0]};
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              rsp_valid,
  input logic              rsp_fault,
  input logic [1:0]        rsp_kind
);
  logic [2:0] rd_cnt;

  always_ff @(posedge clk) begin
    if (rst) rd_cnt <= '0;
    else if (req_valid && req_ready) rd_cnt <= '0;
    else if (mem_req_valid && mem_req_ready) rd_cnt <= rd_cnt + 3'd1;
  end

  assert_idle_no_read_R2: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_req_valid);
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready);
  assert_two_reads_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_fault |-> rd_cnt == 3'd2);
  assert_bound_no_read_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_kind == 2'd1 |-> rd_cnt == 3'd0);
  assert_outer_one_read_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_kind == 2'd2 |-> rd_cnt == 3'd1);
  assert_fault_code_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_fault == (rsp_kind != 2'd0));
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid && req_ready);
endmodule

bind pt_walker ptw_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_addr (mem_req_addr),
  .rsp_valid    (rsp_valid),
  .rsp_fault    (rsp_fault),
  .rsp_kind     (rsp_kind)
);

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic        req_valid = 0;
  logic        req_ready;
  logic [31:0] req_vaddr = 0;
  logic [31:0] req_base = 0;
  logic [10:0] req_len = 0;
  logic        mem_req_valid;
  logic        mem_req_ready = 0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = 0;
  logic        rsp_valid, rsp_fault;
  logic [1:0]  rsp_kind;
  logic [19:0] rsp_frame;
  logic [2:0]  rsp_perm;
  logic [31:0] rsp_paddr;

  always #10 clk = ~clk;

  pt_walker u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_base(req_base), .req_len(req_len),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_kind(rsp_kind), .rsp_frame(rsp_frame), .rsp_perm(rsp_perm),
    .rsp_paddr(rsp_paddr)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic [19:0] frame;
    logic [2:0]  perm;
    logic [31:0] paddr;
    logic [1:0]  nreads;
    logic [31:0] oaddr;
    logic [31:0] iaddr;
  } exp_t;

  exp_t        q[$];
  logic [31:0] mem [logic [31:0]];
  int          n_tests = 0, n_fail = 0;
  int          cyc = 0, lat = 0, nreads = 0;
  logic [31:0] pend_addr, a0, a1, prev_addr;
  bit          prev_stall = 0, prev_rsp = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic exp_t model(input logic [31:0] va, input logic [31:0] base, input logic [10:0] len);
    exp_t e;
    logic [31:0] oe, ie;
    e = '0;
    e.oaddr = base + {20'h0, va[31:22], 2'b00};
    if ({1'b0, va[31:22]} >= len) begin e.kind = 2'd1; return e; end
    oe = rd(e.oaddr);
    e.nreads = 2'd1;
    if (!oe[0]) begin e.kind = 2'd2; return e; end
    e.iaddr = {oe[31:12], va[21:12], 2'b00};
    ie = rd(e.iaddr);
    e.nreads = 2'd2;
    if (!ie[0]) begin e.kind = 2'd3; return e; end
    e.frame = ie[31:12];
    e.perm  = ie[3:1];
    e.paddr = {ie[31:12], va[11:0]};
    return e;
  endfunction

  // memory model, scoreboard monitor and watchdog
  always @(negedge clk) begin
    exp_t e;
    cyc++;
    if (cyc > 50000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 50000);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
    if (!rst) begin
      mem_rsp_valid = 0;
      if (lat > 0) begin
        lat--;
        if (lat == 0) begin mem_rsp_valid = 1; mem_rsp_data = rd(pend_addr); end
      end
      if (prev_stall)
        chk(mem_req_valid && mem_req_addr == prev_addr, "R9 request held", mem_req_addr, prev_addr);
      mem_req_ready = (lat == 0) && !mem_rsp_valid && (cyc % 4 != 1);
      prev_stall = mem_req_valid && !mem_req_ready;
      prev_addr  = mem_req_addr;
      if (mem_req_valid && mem_req_ready) begin
        lat = 1 + cyc % 3;
        pend_addr = mem_req_addr;
        nreads++;
        if (nreads == 1) a0 = mem_req_addr; else a1 = mem_req_addr;
      end
      if (prev_rsp) chk(!rsp_valid && req_ready, "R10 pulse then idle", {rsp_valid, req_ready}, 32'h1);
      prev_rsp = rsp_valid;
      if (rsp_valid) begin
        if (q.size() == 0) begin
          chk(0, "R2 unexpected response", rsp_paddr, 32'h0);
        end else begin
          e = q.pop_front();
          chk(rsp_kind == e.kind, "R6/R7/R8 fault kind", rsp_kind, e.kind);
          chk(rsp_fault == (e.kind != 0), "R8 fault flag", rsp_fault, e.kind != 0);
          chk(nreads == e.nreads, "R5/R6/R7 read count", nreads, e.nreads);
          if (e.nreads >= 1) chk(a0 == e.oaddr, "R3 outer address", a0, e.oaddr);
          if (e.nreads == 2) chk(a1 == e.iaddr, "R4 inner address", a1, e.iaddr);
          if (e.kind == 0) begin
            chk(rsp_frame == e.frame, "R5 frame", rsp_frame, e.frame);
            chk(rsp_perm == e.perm, "R5 perm", rsp_perm, e.perm);
            chk(rsp_paddr == e.paddr, "R5 paddr", rsp_paddr, e.paddr);
          end
        end
        nreads = 0;
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic [31:0] base, input logic [10:0] len);
    while (!req_ready) @(negedge clk);
    q.push_back(model(va, base, len));
    req_valid = 1; req_vaddr = va; req_base = base; req_len = len;
    @(negedge clk);
    req_valid = 0;
  endtask

  function automatic logic [31:0] va_of(input int p1, input int p2, input int off);
    return {p1[9:0], p2[9:0], off[11:0]};
  endfunction

  localparam logic [31:0] B = 32'h0010_0000;

  initial begin
    mem[B + 0*4]    = 32'h0020_0001;
    mem[B + 3*4]    = 32'h0034_0001;
    mem[B + 5*4]    = 32'h0035_0000;
    mem[B + 7*4]    = 32'h0037_0001;
    mem[B + 1023*4] = 32'h0034_0001;
    mem[32'h0020_0000] = 32'h1111_1003;
    mem[32'h0034_0014] = 32'hABCD_E00B;
    mem[32'h0034_0FFC] = 32'h5555_500F;
    mem[32'h0034_0018] = 32'h7777_7006;
    mem[32'h0037_0008] = 32'h0000_100D;

    repeat (3) @(negedge clk);
    chk(req_ready == 1, "R1 ready in reset", req_ready, 1);
    chk(mem_req_valid == 0, "R1 no read in reset", mem_req_valid, 0);
    chk(rsp_valid == 0, "R1 no response in reset", rsp_valid, 0);
    rst = 0;
    @(negedge clk);

    walk(va_of(0, 0, 0), B, 11'd8);          // R5 zero indices
    walk(va_of(3, 5, 12'hABC), B, 11'd8);    // R3 R4 R5
    walk(va_of(3, 1023, 12'hFFF), B, 11'd8); // R5 top inner index
    walk(va_of(5, 9, 0), B, 11'd8);          // R7 outer invalid
    walk(va_of(1, 0, 0), B, 11'd8);          // R7 missing outer entry
    walk(va_of(3, 6, 12'h010), B, 11'd8);    // R8 inner invalid
    walk(va_of(7, 2, 12'h123), B, 11'd8);    // R6 last index in bound
    walk(va_of(8, 2, 12'h123), B, 11'd8);    // R6 first index out of bound
    walk(va_of(0, 0, 0), B, 11'd0);          // R6 zero length
    walk(va_of(1023, 5, 12'h001), B, 11'd1024); // R6 full length

    // R2: requests during a walk are ignored
    walk(va_of(3, 5, 12'h077), B, 11'd8);
    req_valid = 1; req_vaddr = va_of(0, 0, 0); req_len = 11'd8;
    for (int i = 0; i < 3; i++) begin
      chk(req_ready == 0, "R2 busy", req_ready, 0);
      @(negedge clk);
    end
    req_valid = 0;

    for (int i = 0; i < 4; i++) walk(va_of(7, 2, i * 16), B, 11'd8);

    while (q.size() != 0 || !req_ready) @(negedge clk);
    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule